// File: doc/BRIEF.md
# Burst Address Generator

This block sits in front of one port of a memory array. It produces the word address for the access in each clock cycle. A caller can take the address straight from its own bus and capture it. It can also let the block step through consecutive words, keep repeating one word, or jump back to word zero. The caller then streams data on every cycle without presenting a new address each time.

Three active-low controls choose the action for a cycle, in a fixed priority: clear, then strobe (load), then step (increment), then hold. The access address is combinational from the controls and the stored value, so a load or a clear affects the same cycle's access. Every rising edge stores the address just used. The block does not see chip enables or the transfer direction, so the counter runs the same way for reads, writes and deselected cycles.

Top module: `burst_addr_gen`

## Requirements
- R1: With `clear_n` low, `acc_addr` is 0 in that same cycle and the stored value becomes 0 at the edge, whatever `strobe_n`, `step_n` and `ext_addr` are.
- R2: With `clear_n` high and `strobe_n` low, `acc_addr` equals `ext_addr` in that same cycle, and that value is stored at the edge.
- R3: With `clear_n` and `strobe_n` high and `step_n` low, `acc_addr` is the stored value plus one, and that value is stored at the edge. Each step after a load or clear therefore reaches the next word.
- R4: `step_n` has no effect in any cycle where `clear_n` or `strobe_n` is low.
- R5: With `clear_n`, `strobe_n` and `step_n` all high, `acc_addr` repeats the stored value, and `ext_addr` has no effect.
- R6: Stepping from the all-ones address (2^ADDR_W - 1) gives address 0.
- R7: `load_cycle` is 1 exactly in cycles with `clear_n` high and `strobe_n` low, and 0 otherwise, including clear cycles.
- R8: A rising edge with `rst` high sets the stored value to 0, without `clear_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous system reset, active high |
| ext_addr | input | ADDR_W | Address supplied by the caller |
| strobe_n | input | 1 | Active low: use and capture `ext_addr` |
| step_n | input | 1 | Active low: advance to the next word |
| clear_n | input | 1 | Active low: access word 0 and restart from it |
| acc_addr | output | ADDR_W | Address for this cycle's access |
| load_cycle | output | 1 | High when this cycle's address comes from `ext_addr` |

## Verification
The bench builds the block with the default ADDR_W of 14, so the full 16K-word span is covered. After a clear it steps once through every word and checks each address. The run ends at the wrap to zero after 16,384 steps. This width also lets distinct 14-bit patterns show that a load captures every bit, and that a held cycle ignores a changed bus.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              load_cycle
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] held_q;
  logic do_clear, do_load, do_step;

  assign do_clear = ~clear_n;
  assign do_load  = clear_n & ~strobe_n;
  assign do_step  = clear_n & strobe_n & ~step_n;

  assign acc_addr   = do_clear ? '0 :
                      do_load  ? ext_addr :
                      do_step  ? held_q + ONE : held_q;
  assign load_cycle = do_load;

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else     held_q <= acc_addr;
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strobe_n,
  input logic              step_n,
  input logic              clear_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              load_cycle
);
  logic hold_now, step_now;
  assign hold_now = clear_n & strobe_n & step_n;
  assign step_now = clear_n & strobe_n & ~step_n;

  a_r5_hold_repeats: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && hold_now) |-> acc_addr == $past(acc_addr));

  a_r3_step_next: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && step_now) |-> acc_addr == ADDR_W'($past(acc_addr) + 1));

  a_r1_clear_restarts: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!clear_n) && hold_now) |-> acc_addr == '0);

  a_r2_load_captured: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(load_cycle) && hold_now) |-> acc_addr == $past(ext_addr));

  a_r7_flag_excludes_clear: assert property (@(posedge clk) disable iff (rst)
    load_cycle |-> (clear_n && !strobe_n));

  a_r8_sysreset_zero: assert property (@(posedge clk)
    ($past(rst) && !rst && hold_now) |-> acc_addr == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
  .step_n(step_n), .clear_n(clear_n), .acc_addr(acc_addr),
  .load_cycle(load_cycle)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 14;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic strobe_n = 1'b1, step_n = 1'b1, clear_n = 1'b1;
  logic [AW-1:0] acc_addr;
  logic load_cycle;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
    .step_n(step_n), .clear_n(clear_n), .acc_addr(acc_addr),
    .load_cycle(load_cycle)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply controls mid-cycle, check outputs, then let the edge pass
  task automatic cyc(input logic s, input logic e, input logic c, input int a,
                     input string req, input int exp_addr, input int exp_flag);
    @(negedge clk);
    strobe_n = s; step_n = e; clear_n = c; ext_addr = AW'(a);
    #1;
    check(req, int'(acc_addr), exp_addr);
    check("R7", int'(load_cycle), exp_flag);
    @(posedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(1, 1, 1, 0, "R8", 0, 0);
    cyc(1, 1, 1, 0, "R8", 0, 0);
    @(negedge clk); rst = 1'b0;
    cyc(1, 1, 1, 16'h0abc, "R8", 0, 0);
  endtask

  task automatic t_load_hold;
    cyc(0, 1, 1, 16'h1234, "R2", 16'h1234, 1);
    cyc(1, 1, 1, 16'h2222, "R5", 16'h1234, 0);
    cyc(1, 1, 1, 16'h3fff, "R5", 16'h1234, 0);
  endtask

  task automatic t_step;
    cyc(1, 0, 1, 16'h0001, "R3", 16'h1235, 0);
    cyc(1, 0, 1, 16'h0001, "R3", 16'h1236, 0);
    cyc(1, 1, 1, 16'h0001, "R5", 16'h1236, 0);
    cyc(1, 0, 1, 16'h0001, "R3", 16'h1237, 0);
  endtask

  task automatic t_clear_priority;
    cyc(0, 0, 0, 16'h0555, "R1", 0, 0);
    cyc(1, 1, 1, 16'h0555, "R1", 0, 0);
    cyc(1, 0, 1, 16'h0555, "R3", 1, 0);
    cyc(1, 0, 0, 16'h0555, "R4", 0, 0);
    cyc(1, 1, 1, 16'h0555, "R4", 0, 0);
  endtask

  task automatic t_load_over_step;
    cyc(0, 0, 1, 16'h0100, "R4", 16'h0100, 1);
    cyc(1, 1, 1, 16'h0000, "R4", 16'h0100, 0);
    cyc(0, 0, 1, 16'h2aaa, "R2", 16'h2aaa, 1);
    cyc(1, 0, 1, 16'h0000, "R3", 16'h2aab, 0);
  endtask

  task automatic t_wrap;
    cyc(0, 1, 1, TOP, "R6", TOP, 1);
    cyc(1, 0, 1, 0, "R6", 0, 0);
    cyc(1, 0, 1, 0, "R6", 1, 0);
  endtask

  task automatic t_full_walk;
    cyc(1, 1, 0, 16'h1111, "R1", 0, 0);
    for (int i = 1; i <= TOP + 1; i++)
      cyc(1, 0, 1, 16'h1111, "R6", i & TOP, 0);
  endtask

  task automatic t_sysreset_mid;
    cyc(0, 1, 1, 16'h0aaa, "R2", 16'h0aaa, 1);
    @(negedge clk); rst = 1'b1; strobe_n = 1; step_n = 1; clear_n = 1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    cyc(1, 1, 1, 16'h0aaa, "R8", 0, 0);
  endtask

  initial begin
    t_reset();
    t_load_hold();
    t_step();
    t_clear_priority();
    t_load_over_step();
    t_wrap();
    t_sysreset_mid();
    t_full_walk();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule